// File: doc/BRIEF.md
# Inter-Processor Mailbox Transmit Controller

This block is the sending half of a mailbox between processors. The local core reaches it through a simple register port. To send a 64-bit message, software writes the low and high data words and the index of the destination core, and then writes a launch command. If the destination is free, the block copies the message into that destination's own slot and presents it to the remote side. The remote core answers with a one-cycle consume pulse once it has fetched the message.

For each of the eight destinations the block keeps three flags: busy (the message has not been fetched yet), delivered (a message was accepted into the slot) and overflow (a launch arrived while the slot was still busy, so that message was dropped). All 24 flags sit in one status word. Software clears delivered and overflow flags by writing a bit mask. Any flag class can raise an interrupt, each class behind its own mask bit. The interrupt is held in a pending latch until software clears it.

Top module: `mbox_tx_top`

## Requirements
- R1: After reset the status word (0x14) and the interrupt status (0x18) read 0, the interrupt mask (0x1C) reads 0x7, `irqOut` is 0 and no destination slot is valid.
- R2: Word offsets 0x0 (destination index, low 3 bits kept), 0x4 (low data word) and 0x8 (high data word) read back what was written. Read data and `regRdValid` appear in the cycle after the read strobe.
- R3: A write to 0xC with bit 0 = 1 toward a destination whose busy flag is clear does three things. It copies {high word, low word} into that destination's slot. It sets busy (status bit t) and delivered (status bit 16+t). It raises `tgtMsgValid[t]`.
- R4: A write to 0xC with bit 0 = 0 launches nothing. The status word and the slots stay unchanged.
- R5: A launch toward a destination whose busy flag is set sets overflow (status bit 8+t). That destination's slot contents and busy flag are left as they were.
- R6: A consume pulse on `tgtConsume[t]` clears busy bit t and leaves delivered set. When a consume pulse and a launch reach a busy destination in the same cycle, the launch counts as an overflow and busy is cleared.
- R7: A write to 0x10 clears delivered flag t where data bit 16+t is 1 and overflow flag t where data bit 8+t is 1. It never changes a busy flag.
- R8: The mask register 0x1C gates three interrupt sources: bit 0 is any busy flag, bit 1 is any overflow flag and bit 2 is any delivered flag. A 1 blocks the source. An unblocked active source sets the pending latch one cycle later. `irqOut` and bit 0 of 0x18 both show the latch.
- R9: Writing 1 to bit 0 of 0x18 clears the pending latch. While an unblocked source is still active, the latch stays set.
- R10: Destinations are independent: launching to, or consuming on, one destination leaves the flags and slot of every other destination unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 6 | Byte address of the register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, one cycle after the read strobe |
| regRdValid | output | 1 | Marks valid read data |
| tgtConsume | input | 8 | Per-destination pulse: the remote side has fetched its message |
| tgtMsgValid | output | 8 | Per-destination slot holds an unfetched message |
| tgtMsgData | output | 512 | Per-destination 64-bit slot, destination t at bits 64t+63:64t |
| irqOut | output | 1 | Pending interrupt |

## Verification
The hardest case to reach from the ports is a consume pulse and a launch that land on a busy destination in the same clock edge. This case decides whether the dropped message is reported as an overflow. The bench reaches it by raising the consume line in the same half-cycle as the launch write, so both are sampled at one edge. A second hard case is an interrupt clear issued while an unmasked source is still active. The bench produces it by clearing only the interrupt latch, and clears the delivered flags afterwards, before a second clear.

// File: rtl/mbox_tx_pkg.sv
package mbox_tx_pkg;
  localparam int WORD_W = 32;
  localparam int FLD_W  = 8;   // width of each flag field in the status word

  typedef enum logic [3:0] {
    SEL_ID   = 4'd0,
    SEL_LO   = 4'd1,
    SEL_HI   = 4'd2,
    SEL_TRIG = 4'd3,
    SEL_CLR  = 4'd4,
    SEL_STS  = 4'd5,
    SEL_IRQ  = 4'd6,
    SEL_MASK = 4'd7,
    SEL_NONE = 4'd15
  } regSel_t;

  typedef struct packed {
    logic    wrId;
    logic    wrLo;
    logic    wrHi;
    logic    launch;
    logic    clrFlags;
    logic    irqClr;
    logic    wrMask;
    logic    rdEn;
    regSel_t rdSel;
  } ctrlStrb_t;
endpackage

// File: rtl/mbox_tx_ctrl.sv
module mbox_tx_ctrl
  import mbox_tx_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrBit0,
  output ctrlStrb_t         strb
);
  localparam int IDX_W = ADDR_W - 2;

  regSel_t sel;

  always_comb begin
    sel = SEL_NONE;
    if (regAddr[1:0] == 2'b00) begin
      case (regAddr[ADDR_W-1:2])
        IDX_W'(0): sel = SEL_ID;
        IDX_W'(1): sel = SEL_LO;
        IDX_W'(2): sel = SEL_HI;
        IDX_W'(3): sel = SEL_TRIG;
        IDX_W'(4): sel = SEL_CLR;
        IDX_W'(5): sel = SEL_STS;
        IDX_W'(6): sel = SEL_IRQ;
        IDX_W'(7): sel = SEL_MASK;
        default:   sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.rdSel    = sel;
    strb.rdEn     = regRdEn;
    strb.wrId     = regWrEn && (sel == SEL_ID);
    strb.wrLo     = regWrEn && (sel == SEL_LO);
    strb.wrHi     = regWrEn && (sel == SEL_HI);
    strb.launch   = regWrEn && (sel == SEL_TRIG) && wrBit0;
    strb.clrFlags = regWrEn && (sel == SEL_CLR);
    strb.irqClr   = regWrEn && (sel == SEL_IRQ) && wrBit0;
    strb.wrMask   = regWrEn && (sel == SEL_MASK);
  end
endmodule

// File: rtl/mbox_tx_datapath.sv
module mbox_tx_datapath
  import mbox_tx_pkg::*;
#(
  parameter int NUM_TGT = 8,
  parameter int MSG_W   = 2 * WORD_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrb_t                strb,
  input  logic [WORD_W-1:0]        wrData,
  input  logic [NUM_TGT-1:0]       tgtConsume,
  output logic [NUM_TGT-1:0]       tgtMsgValid,
  output logic [NUM_TGT*MSG_W-1:0] tgtMsgData,
  output logic [WORD_W-1:0]        rdData,
  output logic                     rdValid,
  output logic                     irqOut
);
  localparam int ID_W  = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1;
  localparam int SRC_N = 3;

  logic [ID_W-1:0]    idQ;
  logic [WORD_W-1:0]  loQ, hiQ;
  logic [NUM_TGT-1:0] busyQ, delivQ, ovfQ;
  logic [NUM_TGT-1:0] busyN, delivN, ovfN, acceptV;
  logic [SRC_N-1:0]   maskQ, srcAct;
  logic               pendQ, srcHit;

  // Per-destination flag update and message slot
  for (genvar g = 0; g < NUM_TGT; g++) begin : gTgt
    logic             hit, accept, drop;
    logic [MSG_W-1:0] slotQ;

    assign hit        = strb.launch && (idQ == ID_W'(g));
    assign accept     = hit && !busyQ[g];
    assign drop       = hit && busyQ[g];
    assign acceptV[g] = accept;
    assign busyN[g]   = accept ? 1'b1 : (tgtConsume[g] ? 1'b0 : busyQ[g]);
    assign delivN[g]  = accept | (delivQ[g] & ~(strb.clrFlags & wrData[2*FLD_W+g]));
    assign ovfN[g]    = drop   | (ovfQ[g]   & ~(strb.clrFlags & wrData[FLD_W+g]));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       slotQ <= '0;
      else if (accept) slotQ <= {hiQ, loQ};
    end
    assign tgtMsgData[g*MSG_W +: MSG_W] = slotQ;

    AST_CONSUME_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      (tgtConsume[g] && !accept) |=> !busyQ[g]); // R6
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idQ    <= '0;
      loQ    <= '0;
      hiQ    <= '0;
      busyQ  <= '0;
      delivQ <= '0;
      ovfQ   <= '0;
    end else begin
      if (strb.wrId) idQ <= wrData[ID_W-1:0];
      if (strb.wrLo) loQ <= wrData;
      if (strb.wrHi) hiQ <= wrData;
      busyQ  <= busyN;
      delivQ <= delivN;
      ovfQ   <= ovfN;
    end
  end

  // Interrupt: sources are {any delivered, any overflow, any busy}
  assign srcAct = {|delivQ, |ovfQ, |busyQ};
  assign srcHit = |(srcAct & ~maskQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '1;
      pendQ <= 1'b0;
    end else begin
      if (strb.wrMask) maskQ <= wrData[SRC_N-1:0];
      pendQ <= (pendQ & ~strb.irqClr) | srcHit;
    end
  end

  assign irqOut      = pendQ;
  assign tgtMsgValid = busyQ;

  // Registered read port
  logic [WORD_W-1:0] rdMux;
  always_comb begin
    case (strb.rdSel)
      SEL_ID:   rdMux = WORD_W'(idQ);
      SEL_LO:   rdMux = loQ;
      SEL_HI:   rdMux = hiQ;
      SEL_STS:  rdMux = {FLD_W'(0), FLD_W'(delivQ), FLD_W'(ovfQ), FLD_W'(busyQ)};
      SEL_IRQ:  rdMux = WORD_W'(pendQ);
      SEL_MASK: rdMux = WORD_W'(maskQ);
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.rdEn;
      if (strb.rdEn) rdData <= rdMux;
    end
  end

  AST_LAUNCH_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.launch && !busyQ[idQ]) |=> (busyQ[$past(idQ)] && delivQ[$past(idQ)])); // R3
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.launch && busyQ[idQ]) |=> (ovfQ[$past(idQ)] && $stable(tgtMsgData))); // R5
  AST_CLR_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrFlags && !strb.launch && tgtConsume == '0) |=> $stable(busyQ)); // R7
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '1 && !pendQ) |=> !pendQ); // R8
  AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.irqClr && !srcHit) |=> !irqOut); // R9
  AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(acceptV)); // R10
endmodule

// File: rtl/mbox_tx_top.sv
module mbox_tx_top
  import mbox_tx_pkg::*;
#(
  parameter int NUM_TGT = 8,
  parameter int ADDR_W  = 6,
  parameter int MSG_W   = 2 * WORD_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regWrEn,
  input  logic                     regRdEn,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [WORD_W-1:0]        regWrData,
  output logic [WORD_W-1:0]        regRdData,
  output logic                     regRdValid,
  input  logic [NUM_TGT-1:0]       tgtConsume,
  output logic [NUM_TGT-1:0]       tgtMsgValid,
  output logic [NUM_TGT*MSG_W-1:0] tgtMsgData,
  output logic                     irqOut
);
  ctrlStrb_t strb;

  mbox_tx_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .wrBit0  (regWrData[0]),
    .strb    (strb)
  );

  mbox_tx_datapath #(.NUM_TGT(NUM_TGT), .MSG_W(MSG_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (regWrData),
    .tgtConsume  (tgtConsume),
    .tgtMsgValid (tgtMsgValid),
    .tgtMsgData  (tgtMsgData),
    .rdData      (regRdData),
    .rdValid     (regRdValid),
    .irqOut      (irqOut)
  );
endmodule

// File: tb/tb_mbox_tx_top.sv
module tb_mbox_tx_top;
  localparam int NT = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWrEn = 1'b0, regRdEn = 1'b0;
  logic [5:0]   regAddr = '0;
  logic [31:0]  regWrData = '0;
  logic [31:0]  regRdData;
  logic         regRdValid;
  logic [NT-1:0] tgtConsume = '0;
  logic [NT-1:0] tgtMsgValid;
  logic [NT*64-1:0] tgtMsgData;
  logic         irqOut;

  int checks = 0, errors = 0;

  // bench model built from the requirements
  logic [NT-1:0] mBusy = '0, mDeliv = '0, mOvf = '0;
  logic [63:0]   mSlot [NT];

  // scoreboard for register reads
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic [5:0]  adrQ[$];

  always #5 clk = ~clk;

  mbox_tx_top dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .regRdValid(regRdValid), .tgtConsume(tgtConsume),
    .tgtMsgValid(tgtMsgValid), .tgtMsgData(tgtMsgData), .irqOut(irqOut)
  );

  // monitor: pops expected read values as results appear
  always @(negedge clk) begin
    if (rstN && regRdValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected read data: got %h expected none", regRdData);
      end else begin
        automatic logic [31:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        automatic logic [5:0] a = adrQ.pop_front();
        if (regRdData !== e) begin
          errors++;
          $display("FAIL %s read 0x%h: got %h expected %h", t, a, regRdData, e);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readChk(input logic [5:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    expQ.push_back(e); tagQ.push_back(tag); adrQ.push_back(a);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic statusChk(input string tag);
    readChk(6'h14, {8'h0, mDeliv, mOvf, mBusy}, tag);
  endtask

  task automatic slotChk(input string tag);
    chk(tgtMsgValid === mBusy, tag, 64'(tgtMsgValid), 64'(mBusy));
    for (int t = 0; t < NT; t++)
      if (mBusy[t])
        chk(tgtMsgData[t*64 +: 64] === mSlot[t], tag, tgtMsgData[t*64 +: 64], mSlot[t]);
  endtask

  task automatic sendMsg(input int t, input logic [63:0] m);
    busWrite(6'h04, m[31:0]);
    busWrite(6'h08, m[63:32]);
    busWrite(6'h00, 32'(t));
    busWrite(6'h0C, 32'h1);
    if (mBusy[t]) mOvf[t] = 1'b1;
    else begin mBusy[t] = 1'b1; mDeliv[t] = 1'b1; mSlot[t] = m; end
  endtask

  task automatic consume(input int t);
    @(negedge clk);
    tgtConsume[t] = 1'b1;
    @(negedge clk);
    tgtConsume = '0;
    mBusy[t] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk(irqOut === 1'b0, "R1 irqOut", 64'(irqOut), 0);
    chk(tgtMsgValid === '0, "R1 slots", 64'(tgtMsgValid), 0);
    statusChk("R1 status");
    readChk(6'h18, 32'h0, "R1 irq status");
    readChk(6'h1C, 32'h7, "R1 mask");

    // R2 register read-back
    busWrite(6'h04, 32'hA5A5_0001);
    busWrite(6'h08, 32'h5A5A_0002);
    busWrite(6'h00, 32'h0000_00FD);
    readChk(6'h04, 32'hA5A5_0001, "R2 low");
    readChk(6'h08, 32'h5A5A_0002, "R2 high");
    readChk(6'h00, 32'h5, "R2 id");

    // R3 launch to a free destination
    sendMsg(3, 64'h1111_2222_3333_4444);
    statusChk("R3 status");
    slotChk("R3 slot");

    // R4 trigger write with bit0 clear: destination 4 stays idle
    busWrite(6'h00, 32'h4);
    busWrite(6'h0C, 32'h2);
    statusChk("R4 status");
    slotChk("R4 slot");

    // R5 launch to busy destination
    sendMsg(3, 64'hDEAD_BEEF_0BAD_F00D);
    statusChk("R5 status");
    slotChk("R5 slot");

    // R10 independent destinations
    sendMsg(1, 64'h0101_0101_0101_0101);
    sendMsg(2, 64'h0202_0202_0202_0202);
    consume(1);
    statusChk("R10 status");
    slotChk("R10 slot");

    // R6 consume clears busy, delivered stays
    consume(3);
    statusChk("R6 status");
    slotChk("R6 slot");

    // R7 selective clear, busy untouched
    busWrite(6'h10, 32'h0008_0800);
    mDeliv[3] = 1'b0; mOvf[3] = 1'b0;
    statusChk("R7 partial clear");
    busWrite(6'h10, 32'h00FF_FF00);
    mDeliv = '0; mOvf = '0;
    statusChk("R7 full clear");

    // R8 everything masked so far
    chk(irqOut === 1'b0, "R8 masked", 64'(irqOut), 0);

    // R8 delivered source (mask bit2 = 0)
    busWrite(6'h1C, 32'h3);
    @(negedge clk);
    chk(irqOut === 1'b0, "R8 delivered idle", 64'(irqOut), 0);
    sendMsg(7, 64'h7777_0000_7777_0000);
    @(negedge clk);
    chk(irqOut === 1'b1, "R8 delivered irq", 64'(irqOut), 1);
    readChk(6'h18, 32'h1, "R8 irq status");

    // R9 clear while source active keeps pending
    busWrite(6'h18, 32'h1);
    @(negedge clk);
    chk(irqOut === 1'b1, "R9 sticky while active", 64'(irqOut), 1);
    busWrite(6'h10, 32'h00FF_0000);
    mDeliv = '0;
    busWrite(6'h18, 32'h1);
    chk(irqOut === 1'b0, "R9 cleared", 64'(irqOut), 0);
    repeat (2) @(negedge clk);
    chk(irqOut === 1'b0, "R9 stays clear", 64'(irqOut), 0);

    // R8 busy source (mask bit0 = 0); destinations 2 and 7 busy
    busWrite(6'h1C, 32'h6);
    @(negedge clk);
    chk(irqOut === 1'b1, "R8 busy irq", 64'(irqOut), 1);
    consume(2);
    consume(7);
    busWrite(6'h18, 32'h1);
    chk(irqOut === 1'b0, "R8 busy gone", 64'(irqOut), 0);

    // R8 overflow source (mask bit1 = 0)
    busWrite(6'h1C, 32'h5);
    sendMsg(0, 64'h0000_AAAA_0000_BBBB);
    repeat (2) @(negedge clk);
    chk(irqOut === 1'b0, "R8 overflow idle", 64'(irqOut), 0);

    // R6 consume and launch in the same cycle on busy destination 0
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 6'h0C; regWrData = 32'h1;
    tgtConsume[0] = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; tgtConsume = '0;
    mOvf[0] = 1'b1; mBusy[0] = 1'b0;
    statusChk("R6 same-cycle status");
    slotChk("R6 same-cycle slot");
    chk(irqOut === 1'b1, "R8 overflow irq", 64'(irqOut), 1);

    // R8 remask all, clear: overflow flag still set but blocked
    busWrite(6'h1C, 32'h7);
    busWrite(6'h18, 32'h1);
    repeat (2) @(negedge clk);
    chk(irqOut === 1'b0, "R8 remasked", 64'(irqOut), 0);
    readChk(6'h1C, 32'h7, "R8 mask readback");

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R2 pending reads", 64'(expQ.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule